// File: doc/BRIEF.md
# Error-Tolerant Serial Pattern Correlator

This block sits behind a bit synchronizer and watches the recovered NRZ stream, one bit per rising edge of the recovered data clock. On every such edge it shifts the new bit into a history register. It then compares the most recent bits against a programmable 32-bit reference word. If the number of differing bits inside the selected window does not exceed a programmable tolerance, a registered match flag is raised for that clock.

The window length and the error tolerance each come from a 2-bit select. Either can be changed at any time: the new value applies from the next data clock edge, and the bits already received are kept. While the correlator is disabled, or while the upstream synchronizer is not running, the history is emptied and the flag is held low. A fresh window must then be filled before a match can be reported.

Top module: `pattern_correlator`

## Requirements
- R1: After reset is released and before any data edge, `matchFlag` is 0, and the received-bit history is empty.
- R2: On an edge where `corrEnable` is 0, the history and its fill count are cleared, and `matchFlag` is 0 after that edge. Once enable returns, a full window must be received again before a match can occur.
- R3: On an edge where `syncValid` is 0, the block behaves as in R2: the history is cleared and `matchFlag` is 0 after that edge.
- R4: Bit x of `refPattern` is compared with the bit received x edges before the newest one. Bit 0 is compared with the bit sampled on the current edge.
- R5: `sizeSel` codes 0, 1, 2 and 3 select windows of 8, 16, 24 and 32 bits. Only pattern bits 0 up to the window length minus one are compared. Pattern bits above the window have no effect on `matchFlag`.
- R6: A window matches when its count of mismatching bits is less than or equal to the value of `tolSel` (0 to 3).
- R7: `matchFlag` is a register that is updated only on rising `dataClk` edges. After each active edge it reflects the window that includes the bit sampled on that edge.
- R8: No match is flagged until at least as many bits as the current window length have been received since the last reset or clear.
- R9: A change of `sizeSel` or `tolSel` applies on the next edge and does not clear the history or the fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dataClk | input | 1 | Recovered data clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| bitIn | input | 1 | Demodulated NRZ data bit |
| corrEnable | input | 1 | Correlator enable |
| syncValid | input | 1 | High while the upstream bit synchronizer is running |
| refPattern | input | 32 | Reference word; bit 0 pairs with the newest bit |
| sizeSel | input | 2 | Window length select (8, 16, 24, 32 bits) |
| tolSel | input | 2 | Number of tolerated bit errors (0 to 3) |
| matchFlag | output | 1 | Registered match indication |

## Verification
Two situations can coincide on a single edge. In the first, the fill count reaches the window length on the same edge that a select changes or that enable drops. The bench provokes this with an all-zero pattern and an all-zero stream. It widens the window from 8 to 32 bits part-way through, and it drops enable on a cycle that would otherwise match. A match is then expected exactly when the uncleared history reaches 32 bits, and on no edge before that. The second case is a mismatch count that sits exactly at the tolerance boundary. The bench raises the tolerance by one on the edge that follows and checks that the flag goes high at once, with no new fill period.

// File: rtl/corr_pkg.sv
package corr_pkg;
  // Strobes from control to datapath, valid for the coming data edge
  typedef struct packed {
    logic shiftEn;    // sample bitIn into the history
    logic clearHist;  // empty the history and drop the flag
    logic evalEn;     // window is full enough for a match
  } corrStrobe_t;
endpackage

// File: rtl/corr_ctrl.sv
module corr_ctrl
  import corr_pkg::*;
#(
  parameter int PAT_W = 32,
  parameter int SEL_W = 2
) (
  input  logic             dataClk,
  input  logic             rstN,
  input  logic             corrEnable,
  input  logic             syncValid,
  input  logic [SEL_W-1:0] sizeSel,
  output corrStrobe_t      strobe
);
  localparam int STEP  = PAT_W / (1 << SEL_W);
  localparam int CNT_W = $clog2(PAT_W + 1);

  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] fillNext;
  logic [CNT_W-1:0] winLen;
  logic             active;

  assign active   = corrEnable && syncValid;
  assign winLen   = CNT_W'((32'(sizeSel) + 32'd1) * 32'(STEP));
  assign fillNext = (fillCnt == CNT_W'(PAT_W)) ? fillCnt : fillCnt + CNT_W'(1);

  always_ff @(posedge dataClk or negedge rstN) begin
    if (!rstN)       fillCnt <= '0;
    else if (!active) fillCnt <= '0;
    else             fillCnt <= fillNext;
  end

  always_comb begin
    strobe.shiftEn   = active;
    strobe.clearHist = !active;
    strobe.evalEn    = active && (fillNext >= winLen);
  end
endmodule

// File: rtl/corr_datapath.sv
module corr_datapath
  import corr_pkg::*;
#(
  parameter int PAT_W = 32,
  parameter int SEL_W = 2
) (
  input  logic             dataClk,
  input  logic             rstN,
  input  logic             bitIn,
  input  logic [PAT_W-1:0] refPattern,
  input  logic [SEL_W-1:0] sizeSel,
  input  logic [SEL_W-1:0] tolSel,
  input  corrStrobe_t      strobe,
  output logic             matchFlag
);
  localparam int STEP  = PAT_W / (1 << SEL_W);
  localparam int CNT_W = $clog2(PAT_W + 1);

  logic [PAT_W-1:0] hist;
  logic [PAT_W-1:0] histNext;
  logic [PAT_W-1:0] winMask;
  logic [PAT_W-1:0] mismatch;
  logic [CNT_W-1:0] errCnt;
  logic             inTol;

  // newest bit lands in position 0
  assign histNext = {hist[PAT_W-2:0], bitIn};

  for (genvar g = 0; g < PAT_W; g++) begin : gen_mask
    assign winMask[g] = (32'(sizeSel) >= 32'(g / STEP));
  end

  assign mismatch = (histNext ^ refPattern) & winMask;

  always_comb begin
    errCnt = '0;
    for (int i = 0; i < PAT_W; i++) errCnt = errCnt + CNT_W'(mismatch[i]);
  end

  assign inTol = (errCnt <= CNT_W'(tolSel));

  always_ff @(posedge dataClk or negedge rstN) begin
    if (!rstN) begin
      hist      <= '0;
      matchFlag <= 1'b0;
    end else if (strobe.clearHist) begin
      hist      <= '0;
      matchFlag <= 1'b0;
    end else if (strobe.shiftEn) begin
      hist      <= histNext;
      matchFlag <= strobe.evalEn && inTol;
    end
  end
endmodule

// File: rtl/pattern_correlator.sv
module pattern_correlator
  import corr_pkg::*;
#(
  parameter int PAT_W = 32,
  parameter int SEL_W = 2
) (
  input  logic             dataClk,
  input  logic             rstN,
  input  logic             bitIn,
  input  logic             corrEnable,
  input  logic             syncValid,
  input  logic [PAT_W-1:0] refPattern,
  input  logic [SEL_W-1:0] sizeSel,
  input  logic [SEL_W-1:0] tolSel,
  output logic             matchFlag
);
  corrStrobe_t strobe;

  corr_ctrl #(.PAT_W(PAT_W), .SEL_W(SEL_W)) u_ctrl (
    .dataClk    (dataClk),
    .rstN       (rstN),
    .corrEnable (corrEnable),
    .syncValid  (syncValid),
    .sizeSel    (sizeSel),
    .strobe     (strobe)
  );

  corr_datapath #(.PAT_W(PAT_W), .SEL_W(SEL_W)) u_dp (
    .dataClk    (dataClk),
    .rstN       (rstN),
    .bitIn      (bitIn),
    .refPattern (refPattern),
    .sizeSel    (sizeSel),
    .tolSel     (tolSel),
    .strobe     (strobe),
    .matchFlag  (matchFlag)
  );
endmodule

// File: rtl/corr_checker.sv
module corr_checker #(
  parameter int PAT_W = 32,
  parameter int SEL_W = 2
) (
  input logic             dataClk,
  input logic             rstN,
  input logic             corrEnable,
  input logic             syncValid,
  input logic [SEL_W-1:0] sizeSel,
  input logic             matchFlag
);
  localparam int STEP = PAT_W / (1 << SEL_W);

  int unsigned chkCnt;
  int unsigned chkWin;

  assign chkWin = (32'(sizeSel) + 1) * STEP;

  always_ff @(posedge dataClk or negedge rstN) begin
    if (!rstN)                         chkCnt <= 0;
    else if (!(corrEnable && syncValid)) chkCnt <= 0;
    else if (chkCnt < PAT_W)           chkCnt <= chkCnt + 1;
  end

  // R2
  enable_off_chk: assert property (@(posedge dataClk) disable iff (!rstN)
    !corrEnable |=> !matchFlag);

  // R3
  sync_off_chk: assert property (@(posedge dataClk) disable iff (!rstN)
    !syncValid |=> !matchFlag);

  // R8
  fill_guard_chk: assert property (@(posedge dataClk) disable iff (!rstN)
    (corrEnable && syncValid && (chkCnt + 1 < chkWin)) |=> !matchFlag);

  // R7
  rise_when_active_chk: assert property (@(posedge dataClk) disable iff (!rstN)
    $rose(matchFlag) |-> $past(corrEnable && syncValid));
endmodule

bind pattern_correlator corr_checker #(.PAT_W(PAT_W), .SEL_W(SEL_W)) u_chk (
  .dataClk    (dataClk),
  .rstN       (rstN),
  .corrEnable (corrEnable),
  .syncValid  (syncValid),
  .sizeSel    (sizeSel),
  .matchFlag  (matchFlag)
);

// File: tb/test_pattern_correlator.sv
module test_pattern_correlator;
  localparam int CLK_PERIOD = 10;

  logic        dataClk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitIn = 1'b0;
  logic        corrEnable = 1'b0;
  logic        syncValid = 1'b0;
  logic [31:0] refPattern = '0;
  logic [1:0]  sizeSel = 2'd0;
  logic [1:0]  tolSel = 2'd0;
  logic        matchFlag;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench-side model of the requirements
  logic [31:0] mHist = '0;
  int          mCount = 0;

  always #(CLK_PERIOD/2) dataClk = ~dataClk;

  pattern_correlator i_pattern_correlator (
    .dataClk(dataClk), .rstN(rstN), .bitIn(bitIn), .corrEnable(corrEnable),
    .syncValid(syncValid), .refPattern(refPattern), .sizeSel(sizeSel),
    .tolSel(tolSel), .matchFlag(matchFlag)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: matchFlag=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic modelEdge(input logic b);
    int len;
    logic [31:0] mask;
    if (!(corrEnable && syncValid)) begin
      mHist = '0; mCount = 0;
      return 1'b0;
    end
    mHist = {mHist[30:0], b};
    if (mCount < 32) mCount++;
    len = (int'(sizeSel) + 1) * 8;
    mask = (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
    return (mCount >= len) && ($countones((mHist ^ refPattern) & mask) <= int'(tolSel));
  endfunction

  // drives one bit, checks model; returns the flag seen
  task automatic sendBit(input logic b, input string req, output logic seen);
    logic exp;
    @(negedge dataClk);
    bitIn = b;
    exp = modelEdge(b);
    @(posedge dataClk);
    #1;
    seen = matchFlag;
    check(matchFlag, exp, req);
  endtask

  task automatic clearAll();
    logic s;
    corrEnable = 1'b0;
    sendBit(1'b0, "R2", s);
    corrEnable = 1'b1;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge dataClk);
    #1 check(matchFlag, 1'b0, "R1");
    @(negedge dataClk) rstN = 1'b1;
    #1 check(matchFlag, 1'b0, "R1");
  endtask

  task automatic testExact8();
    logic s;
    refPattern = 32'h3C19_E4A5; sizeSel = 2'd0; tolSel = 2'd0;
    corrEnable = 1'b1; syncValid = 1'b1;
    for (int x = 7; x >= 0; x--) sendBit(refPattern[x], "R4 R8", s);
    check(s, 1'b1, "R4 exact 8-bit window");
    sendBit(1'b1, "R7", s);
    check(s, 1'b0, "R7 shifted window no longer matches");
  endtask

  task automatic testSizes();
    logic s;
    refPattern = 32'h9D2B_6F41;
    for (int sz = 0; sz < 4; sz++) begin
      clearAll();
      sizeSel = 2'(sz);
      for (int x = (sz + 1) * 8 - 1; x >= 0; x--)
        sendBit((x == (sz + 1) * 8 - 1) ? refPattern[x] : refPattern[x], "R5", s);
      check(s, 1'b1, "R5 full window match");
    end
    // bits above a 16-bit window ignored: stream disagrees above bit 15
    clearAll(); sizeSel = 2'd1;
    for (int x = 31; x >= 0; x--) sendBit((x > 15) ? ~refPattern[x] : refPattern[x], "R5", s);
    check(s, 1'b1, "R5 bits above window ignored");
  endtask

  task automatic testTolerance();
    logic s;
    refPattern = 32'h0000_C3A5; sizeSel = 2'd1;
    for (int t = 0; t < 4; t++) begin
      clearAll(); tolSel = 2'(t);
      // three errors at positions 2, 7 and 12 from the newest
      for (int x = 15; x >= 0; x--)
        sendBit((x == 2 || x == 7 || x == 12) ? ~refPattern[x] : refPattern[x], "R6", s);
      check(s, (t >= 3) ? 1'b1 : 1'b0, "R6 three errors against tolerance");
    end
  endtask

  task automatic testEnableSync();
    logic s;
    refPattern = '0; sizeSel = 2'd0; tolSel = 2'd0;
    clearAll();
    for (int i = 0; i < 10; i++) sendBit(1'b0, "R8", s);
    check(s, 1'b1, "R8 zeros match after fill");
    corrEnable = 1'b0;
    sendBit(1'b0, "R2", s);
    check(s, 1'b0, "R2 enable low forces flag low");
    corrEnable = 1'b1;
    for (int i = 0; i < 7; i++) sendBit(1'b0, "R2", s);
    check(s, 1'b0, "R2 history refilled only 7 bits");
    sendBit(1'b0, "R2", s);
    check(s, 1'b1, "R2 match after full refill");
    syncValid = 1'b0;
    sendBit(1'b0, "R3", s);
    check(s, 1'b0, "R3 sync loss forces flag low");
    syncValid = 1'b1;
    for (int i = 0; i < 7; i++) sendBit(1'b0, "R3", s);
    check(s, 1'b0, "R3 history cleared on sync loss");
  endtask

  task automatic testLiveChange();
    logic s;
    refPattern = '0; sizeSel = 2'd0; tolSel = 2'd0;
    clearAll();
    for (int i = 0; i < 20; i++) sendBit(1'b0, "R9", s);
    check(s, 1'b1, "R9 8-bit window matched");
    sizeSel = 2'd3;
    for (int i = 21; i < 32; i++) sendBit(1'b0, "R9", s);
    check(s, 1'b0, "R9 31 bits held, 32 window not yet full");
    sendBit(1'b0, "R9", s);
    check(s, 1'b1, "R9 history kept across size change");
    // one error at the newest position, tolerance raised on next edge
    sendBit(1'b1, "R9", s);
    check(s, 1'b0, "R9 one error with tolerance 0");
    tolSel = 2'd1;
    sendBit(1'b0, "R9", s);
    check(s, 1'b1, "R9 tolerance change applies on next edge");
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    testReset();
    testExact8();
    testSizes();
    testTolerance();
    testEnableSync();
    testLiveChange();
    finished = 1;
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge dataClk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual running expected done");
      finishRun();
    end
  end
endmodule